// File: doc/BRIEF.md
# Four-Bit ALU Slice with Group Carry Terms

This block is a 4-bit arithmetic and logic slice. A mode input picks between two families of sixteen functions: in logic mode every result bit is an independent two-input boolean function of the matching operand bits, and in arithmetic mode the slice adds a pair of operands derived from A and B, with carries formed by full lookahead inside the slice. A select code of four bits chooses the function within the family.

The carry input, carry output and the group generate and propagate outputs all use low-true signalling. Wider words are built either by chaining slices through the carry pins or by feeding the group terms to an external lookahead unit. The group terms do not depend on the carry input, and the carry output always equals the group generate term OR'd with the group propagate term AND'd with the incoming carry. A flag reports a result of all ones, which after a subtract-minus-one means the operands match. The outputs pass through one register stage (parameter `REG_OUT`, default 1) so that the slice can be checked on a clock; with `REG_OUT` set to 0 it is purely combinational.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode` high, each result bit i depends only on opa[i] and opb[i]. By `func_sel`: 4'b0000 NOT A, 4'b0001 NOR, 4'b0010 (NOT A) AND B, 4'b0011 zero, 4'b0100 NAND, 4'b0101 NOT B, 4'b0110 XOR, 4'b0111 A AND (NOT B), 4'b1000 (NOT A) OR B, 4'b1001 XNOR, 4'b1010 B, 4'b1011 AND, 4'b1100 all ones, 4'b1101 A OR (NOT B), 4'b1110 OR, 4'b1111 A.
- R2: With `logic_mode` low, result is the low four bits of X + Y + c, where c is 1 when `carry_in_n` is low and 0 when it is high. The pair (X, Y) by `func_sel`: 0000 (A, 0); 0001 (A|B, 0); 0010 (A|~B, 0); 0011 (0, 15); 0100 (A, A&~B); 0101 (A|B, A&~B); 0110 (A, ~B); 0111 (A&~B, 15); 1000 (A, A&B); 1001 (A, B); 1010 (A|~B, A&B); 1011 (A&B, 15); 1100 (A, A); 1101 (A|B, A); 1110 (A|~B, A); 1111 (A, 15). So 1001 is A plus B, 0110 is A minus B minus 1 (A minus B with carry applied), 1100 doubles A, 0011 gives all ones and 1111 gives A minus 1.
- R3: `carry_out_n` is low exactly when X + Y + c is 16 or more.
- R4: For select 0110 the carry output is a not-borrow: with carry applied, `carry_out_n` is low when A >= B and high when A < B.
- R5: `grp_gen_n` is low exactly when X + Y is 16 or more, whatever the carry input.
- R6: `grp_prop_n` low implies X + Y is 15 or more, and at least one of `grp_gen_n` and `grp_prop_n` is low exactly when X + Y is 15 or more; the carry output equals generate OR (propagate AND carry-in) in true polarity.
- R7: `carry_out_n`, `grp_gen_n` and `grp_prop_n` follow R3, R5 and R6 with the same (X, Y) in logic mode as in arithmetic mode.
- R8: `eq_flag` is high exactly when all four result bits are high; select 0110 in arithmetic mode with `carry_in_n` high raises it exactly when A equals B.
- R9: With `REG_OUT` = 1 every output reflects the inputs present at the previous rising clock edge; while `rst` is high the outputs are result 0, `eq_flag` 0 and the three low-true carry outputs 1.
- R10: Four slices chained from carry output to carry input form a 16-bit adder (select 1001, no carry) and subtractor (select 0110, carry applied) whose results and final carry match integer arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| func_sel | input | 4 | Function select code |
| logic_mode | input | 1 | High for bitwise logic, low for arithmetic |
| carry_in_n | input | 1 | Incoming carry, low-true |
| result | output | 4 | Function result |
| carry_out_n | output | 1 | Ripple carry out, low-true |
| grp_gen_n | output | 1 | Group generate, low-true |
| grp_prop_n | output | 1 | Group propagate, low-true |
| eq_flag | output | 1 | High when the result is all ones |

## Verification
The properties assume a registered build, in which every output is a function of the inputs seen one edge earlier, and that the inputs hold steady between rising edges so a single past sample describes them. They are only checked from the second cycle after reset, once the register holds a value computed from real inputs. The stimulus changes inputs only at falling edges and, in the chained case, lets the carry ripple settle over several held cycles before sampling, so both assumptions hold throughout.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SLICE_W = 4;
    localparam int SEL_W   = 4;

    typedef logic [SLICE_W-1:0] word_t;
    typedef logic [SEL_W-1:0]   sel_t;

    // registered view of the slice outputs, true/low-true as on the pins
    typedef struct packed {
        word_t result;
        logic  carry_out_n;
        logic  grp_gen_n;
        logic  grp_prop_n;
        logic  eq_flag;
    } slice_out_t;

    localparam slice_out_t SLICE_OUT_RST = '{
        result:      '0,
        carry_out_n: 1'b1,
        grp_gen_n:   1'b1,
        grp_prop_n:  1'b1,
        eq_flag:     1'b0
    };

    // per-bit propagate term: A OR (B gated by s0) OR (not B gated by s1)
    function automatic logic bit_prop(input logic a, input logic b, input sel_t s);
        return a | (b & s[0]) | (~b & s[1]);
    endfunction

    // per-bit generate term: A AND (not B gated by s2 OR B gated by s3)
    function automatic logic bit_gen(input logic a, input logic b, input sel_t s);
        return (a & ~b & s[2]) | (a & b & s[3]);
    endfunction

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [SEL_W-1:0] func_sel,
    output logic [W-1:0]     prop,
    output logic [W-1:0]     gen
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign prop[i] = bit_prop(opa[i], opb[i], func_sel);
        assign gen[i]  = bit_gen(opa[i], opb[i], func_sel);
    end
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic         carry0,
    output logic [W-1:0] bit_carry,
    output logic         grp_gen,
    output logic         grp_prop,
    output logic         carry_out
);
    localparam int NC = W + 1;

    logic [NC-1:0] cvec;

    // carry into position i as a flat sum of products (no ripple chain)
    for (genvar i = 0; i < NC; i++) begin : g_carry
        logic c_i;
        always_comb begin
            logic term;
            c_i  = 1'b0;
            for (int j = 0; j < i; j++) begin
                term = gen[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & prop[k];
                end
                c_i = c_i | term;
            end
            term = carry0;
            for (int k = 0; k < i; k++) begin
                term = term & prop[k];
            end
            c_i = c_i | term;
        end
        assign cvec[i] = c_i;
    end

    // group generate: same product sum but without any incoming carry
    always_comb begin
        logic term;
        grp_gen = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = gen[j];
            for (int k = j + 1; k < W; k++) begin
                term = term & prop[k];
            end
            grp_gen = grp_gen | term;
        end
    end

    assign grp_prop  = &prop;
    assign bit_carry = cvec[W-1:0];
    assign carry_out = cvec[W];
endmodule

// File: rtl/alu_result.sv
module alu_result #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic [W-1:0] bit_carry,
    input  logic         logic_mode,
    output logic [W-1:0] result,
    output logic         eq_flag
);
    logic [W-1:0] half_sum;
    logic [W-1:0] carry_mask;

    assign half_sum   = prop & ~gen;
    // logic mode blocks all carries; the constant mask inverts each half sum
    assign carry_mask = logic_mode ? {W{1'b1}} : bit_carry;
    assign result     = half_sum ^ carry_mask;
    assign eq_flag    = &result;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLICE_W-1:0] opa,
    input  logic [SLICE_W-1:0] opb,
    input  logic [SEL_W-1:0]   func_sel,
    input  logic              logic_mode,
    input  logic              carry_in_n,
    output logic [SLICE_W-1:0] result,
    output logic              carry_out_n,
    output logic              grp_gen_n,
    output logic              grp_prop_n,
    output logic              eq_flag
);
    word_t      prop, gen, bit_carry, res_c;
    logic       grp_gen, grp_prop, carry_out, eq_c;
    slice_out_t nxt, cur;

    alu_bit_terms #(.W(SLICE_W)) u_terms (
        .opa      (opa),
        .opb      (opb),
        .func_sel (func_sel),
        .prop     (prop),
        .gen      (gen)
    );

    alu_lookahead #(.W(SLICE_W)) u_cla (
        .prop      (prop),
        .gen       (gen),
        .carry0    (~carry_in_n),
        .bit_carry (bit_carry),
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop),
        .carry_out (carry_out)
    );

    alu_result #(.W(SLICE_W)) u_res (
        .prop       (prop),
        .gen        (gen),
        .bit_carry  (bit_carry),
        .logic_mode (logic_mode),
        .result     (res_c),
        .eq_flag    (eq_c)
    );

    always_comb begin
        nxt.result      = res_c;
        nxt.carry_out_n = ~carry_out;
        nxt.grp_gen_n   = ~grp_gen;
        nxt.grp_prop_n  = ~grp_prop;
        nxt.eq_flag     = eq_c;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cur <= SLICE_OUT_RST;
            end else begin
                cur <= nxt;
            end
        end
    end else begin : g_comb
        assign cur = nxt;
    end

    assign result      = cur.result;
    assign carry_out_n = cur.carry_out_n;
    assign grp_gen_n   = cur.grp_gen_n;
    assign grp_prop_n  = cur.grp_prop_n;
    assign eq_flag     = cur.eq_flag;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opa,
    input logic [3:0] opb,
    input logic [3:0] func_sel,
    input logic       logic_mode,
    input logic       carry_in_n,
    input logic [3:0] result,
    input logic       carry_out_n,
    input logic       grp_gen_n,
    input logic       grp_prop_n,
    input logic       eq_flag
);
    if (REG_OUT) begin : g_props
        logic primed;
        always_ff @(posedge clk) begin
            if (rst) primed <= 1'b0;
            else     primed <= 1'b1;
        end

        // R9
        rst_vals_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (result == 4'h0 && !eq_flag && carry_out_n && grp_gen_n && grp_prop_n));

        // R8
        eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
            eq_flag == (result == 4'hF));

        // R6
        carry_join_chk: assert property (@(posedge clk) disable iff (rst || !primed)
            (!carry_out_n) == (!grp_gen_n || (!grp_prop_n && !$past(carry_in_n))));

        // R1
        logic_pass_b_chk: assert property (@(posedge clk) disable iff (rst || !primed)
            $past(logic_mode && func_sel == 4'b1010) |-> result == $past(opb));

        // R2
        double_a_chk: assert property (@(posedge clk) disable iff (rst || !primed)
            $past(!logic_mode && func_sel == 4'b1100 && carry_in_n) |-> result == {$past(opa[2:0]), 1'b0});

        // R8
        sub_equal_chk: assert property (@(posedge clk) disable iff (rst || !primed)
            $past(!logic_mode && func_sel == 4'b0110 && carry_in_n && opa == opb) |-> eq_flag);

        // R5
        all_prop_chk: assert property (@(posedge clk) disable iff (rst || !primed)
            $past(func_sel == 4'b0011) |-> (!grp_prop_n && grp_gen_n));
    end
endmodule

bind alu_slice alu_slice_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .opa         (opa),
    .opb         (opb),
    .func_sel    (func_sel),
    .logic_mode  (logic_mode),
    .carry_in_n  (carry_in_n),
    .result      (result),
    .carry_out_n (carry_out_n),
    .grp_gen_n   (grp_gen_n),
    .grp_prop_n  (grp_prop_n),
    .eq_flag     (eq_flag)
);

// File: tb/tb_alu_slice.sv
module tb_alu_slice;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic [3:0] a = '0, b = '0, s = '0;
    logic       m = 1'b0, cn = 1'b1;
    logic [3:0] f;
    logic       co_n, g_n, p_n, eq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    alu_slice dut (
        .clk(clk), .rst(rst), .opa(a), .opb(b), .func_sel(s),
        .logic_mode(m), .carry_in_n(cn), .result(f), .carry_out_n(co_n),
        .grp_gen_n(g_n), .grp_prop_n(p_n), .eq_flag(eq)
    );

    // four-slice chain for R10
    logic [15:0] ca = '0, cb = '0;
    logic [3:0]  cs = 4'b1001;
    logic        ccin_n = 1'b1;
    logic [4:0]  cc_n;
    logic [15:0] cf;
    assign cc_n[0] = ccin_n;
    for (genvar k = 0; k < 4; k++) begin : g_chain
        logic gk, pk, ek;
        alu_slice u_sl (
            .clk(clk), .rst(rst), .opa(ca[4*k +: 4]), .opb(cb[4*k +: 4]),
            .func_sel(cs), .logic_mode(1'b0), .carry_in_n(cc_n[k]),
            .result(cf[4*k +: 4]), .carry_out_n(cc_n[k+1]),
            .grp_gen_n(gk), .grp_prop_n(pk), .eq_flag(ek)
        );
    end

    typedef struct {
        logic [3:0] a, b, s;
        logic       m, cn;
    } vec_t;
    vec_t pend[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void operands(input logic [3:0] x_a, x_b, sel, output int x, output int y);
        logic [3:0] nb;
        nb = ~x_b;
        case (sel)
            4'b0000: begin x = x_a;          y = 0;           end
            4'b0001: begin x = x_a | x_b;    y = 0;           end
            4'b0010: begin x = x_a | nb;     y = 0;           end
            4'b0011: begin x = 0;            y = 15;          end
            4'b0100: begin x = x_a;          y = x_a & nb;    end
            4'b0101: begin x = x_a | x_b;    y = x_a & nb;    end
            4'b0110: begin x = x_a;          y = nb;          end
            4'b0111: begin x = x_a & nb;     y = 15;          end
            4'b1000: begin x = x_a;          y = x_a & x_b;   end
            4'b1001: begin x = x_a;          y = x_b;         end
            4'b1010: begin x = x_a | nb;     y = x_a & x_b;   end
            4'b1011: begin x = x_a & x_b;    y = 15;          end
            4'b1100: begin x = x_a;          y = x_a;         end
            4'b1101: begin x = x_a | x_b;    y = x_a;         end
            4'b1110: begin x = x_a | nb;     y = x_a;         end
            default: begin x = x_a;          y = 15;          end
        endcase
    endfunction

    function automatic logic [3:0] logic_ref(input logic [3:0] x_a, x_b, sel);
        case (sel)
            4'b0000: return ~x_a;
            4'b0001: return ~(x_a | x_b);
            4'b0010: return ~x_a & x_b;
            4'b0011: return 4'h0;
            4'b0100: return ~(x_a & x_b);
            4'b0101: return ~x_b;
            4'b0110: return x_a ^ x_b;
            4'b0111: return x_a & ~x_b;
            4'b1000: return ~x_a | x_b;
            4'b1001: return ~(x_a ^ x_b);
            4'b1010: return x_b;
            4'b1011: return x_a & x_b;
            4'b1100: return 4'hF;
            4'b1101: return x_a | ~x_b;
            4'b1110: return x_a | x_b;
            default: return x_a;
        endcase
    endfunction

    task automatic compare(input vec_t v);
        int x, y, raw, tot;
        logic [3:0] ef;
        bit g_exp, gp_ok;
        operands(v.a, v.b, v.s, x, y);
        raw = x + y;
        tot = raw + (v.cn ? 0 : 1);
        ef  = v.m ? logic_ref(v.a, v.b, v.s) : tot[3:0];
        if (v.m) chk(f == ef, "R1 logic result", f, ef);
        else     chk(f == ef, "R2 arith result", f, ef);
        if (!v.m && v.s == 4'b0110 && !v.cn)
            chk(co_n == !(v.a >= v.b), "R4 not-borrow", co_n, !(v.a >= v.b));
        else if (v.m)
            chk(co_n == !(tot >= 16), "R7 carry in logic mode", co_n, !(tot >= 16));
        else
            chk(co_n == !(tot >= 16), "R3 carry out", co_n, !(tot >= 16));
        g_exp = (raw >= 16);
        chk(g_n == !g_exp, v.m ? "R7 generate" : "R5 generate", g_n, !g_exp);
        gp_ok = (((!p_n) || (!g_n)) == (raw >= 15)) && (p_n || (raw >= 15));
        chk(gp_ok, v.m ? "R7 propagate" : "R6 propagate", {p_n, g_n}, raw);
        chk(eq == (ef == 4'hF), "R8 eq flag", eq, ef == 4'hF);
    endtask

    initial begin
        a = 4'h5; b = 4'hA; s = 4'b1001; m = 1'b0; cn = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset values
        chk(f == 4'h0 && !eq && co_n && g_n && p_n, "R9 reset state",
            {f, co_n, g_n, p_n, eq}, 8'b0000_1110);
        rst = 1'b0;
        for (int n = 0; n < 16384; n++) begin
            vec_t v;
            v.a  = n[3:0];
            v.b  = n[7:4];
            v.s  = n[11:8];
            v.m  = n[12];
            v.cn = n[13];
            a = v.a; b = v.b; s = v.s; m = v.m; cn = v.cn;
            pend.push_back(v);
            @(negedge clk);
            compare(pend.pop_front());
        end
        // R10 chained 16-bit add and subtract
        for (int t = 0; t < 300; t++) begin
            bit sub;
            logic [16:0] exp_sum;
            sub = t[0];
            ca = (t < 4) ? {16{t[1]}} : $urandom();
            cb = (t < 4) ? 16'h0001 : $urandom();
            if (t == 6) cb = ca;
            cs = sub ? 4'b0110 : 4'b1001;
            ccin_n = sub ? 1'b0 : 1'b1;
            repeat (6) @(negedge clk);
            if (sub) begin
                exp_sum = {1'b0, ca - cb};
                chk(cf == exp_sum[15:0], "R10 chained subtract", cf, exp_sum[15:0]);
                chk(cc_n[4] == !(ca >= cb), "R10 chained not-borrow", cc_n[4], !(ca >= cb));
            end else begin
                exp_sum = {1'b0, ca} + {1'b0, cb};
                chk(cf == exp_sum[15:0], "R10 chained add", cf, exp_sum[15:0]);
                chk(cc_n[4] == !exp_sum[16], "R10 chained carry", cc_n[4], !exp_sum[16]);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule